// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire (I2C) serial memory. It sits in front of a 256-byte array and runs on a fast system clock. Both bus lines are synchronised and cleaned of short spikes. Start and Stop are then found on the cleaned lines. After a Start, the block compares the select byte with a fixed 4-bit identifier and three strap pins. It acknowledges each accepted byte. In a write, the byte after the select loads the word pointer. The data bytes that follow go into a 16-byte page buffer.

The buffer reaches the array only when the master sends Stop. The whole page is written in one system cycle. After a commit the block stays busy for a set number of cycles and ignores the bus for that time. There are two ways to refuse a commit. A write-protect pin guards the whole array. A one-time lock guards addresses 0 to 127: a pulse on a sideband input sets the lock, and nothing clears it, reset included. Reads return the byte at the pointer and then step the pointer, wrapping from 255 to 0. SDA is pulled low only through `sda_oe`, and it changes only after SCL has been low for a set hold time.

Top module: `twi_eeprom`

## Requirements
- R1: While `rst_n` is low and just after it, `sda_oe` and `busy_o` are 0 and every array byte reads 0x00.
- R2: The first byte after Start is {4'b1010, strap_a[2:0], rw} sent MSB first. Only a match is acknowledged. After a mismatch, nothing is acknowledged until the next Start.
- R3: In a write (rw=0), the byte after the select loads the word pointer. Each accepted byte gets SDA pulled low during the ninth SCL pulse.
- R4: Write data bytes are stored in the page buffer at the pointer's low 4 bits. The pointer advances after each byte.
- R5: In a write, the pointer advances only within its 16-byte page: the low 4 bits roll over and the upper 4 bits are held. A 17th or later byte overwrites the earlier byte at the same slot.
- R6: Nothing reaches the array before Stop. A Start that comes before the Stop discards the pending data.
- R7: A Stop after at least one write data byte, when the commit is not blocked, writes the buffered bytes. `busy_o` then stays 1 for exactly WR_CYC system cycles.
- R8: While `busy_o` is 1, the block acknowledges nothing, not even its own select byte.
- R9: A read (rw=1) returns the byte at the pointer and then adds 1 to the pointer, wrapping from 255 to 0 across page boundaries. A master ACK asks for the next byte. A NACK ends the read.
- R10: With `wp_i` high at Stop, no byte is written and `busy_o` stays 0.
- R11: A high level on `lock_set_i` sets `lock_o` forever, and `rst_n` does not clear it. With the lock set, a commit to a page in 0..127 is refused with no busy window, while pages in 128..255 are still written. A lock pulse that falls in the commit cycle already blocks that commit.
- R12: A pulse shorter than SPIKE_CYC system cycles on SCL or SDA has no effect on the protocol.
- R13: `sda_oe` changes only while SCL is low, and no sooner than HOLD_CYC system cycles after SCL falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| strap_a | input | 3 | Device address straps |
| wp_i | input | 1 | Whole-array write-protect level |
| lock_set_i | input | 1 | Pulse that permanently locks the lower half |
| sda_oe | output | 1 | 1 = pull SDA low |
| busy_o | output | 1 | Internal write cycle in progress |
| lock_o | output | 1 | Lower-half lock is set |

## Verification
Setting the one-time lock and committing a page can happen in the same system cycle, and the lock must then already block that commit. The bench holds `lock_set_i` high across the whole Stop of a write to a lower-half page. The commit cycle therefore falls inside the pulse. The bench then judges the result at the ports: `busy_o` must stay low, `lock_o` must be 1, and a read-back must still return the old byte. Separately, the bench checks that a Start arriving while the busy window is open is ignored, so the device does not acknowledge its own select byte.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

  localparam int ADDR_W = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SEL,
    S_WADR,
    S_WDAT,
    S_RDAT
  } phase_e;

  // pointer step inside a page of 2**pb bytes: upper bits held
  function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] p, input int pb);
    logic [ADDR_W-1:0] m;
    m = ADDR_W'((1 << pb) - 1);
    return (p & ~m) | ((p + 1'b1) & m);
  endfunction

  // pointer step for reads: whole array, wraps at the top
  function automatic logic [ADDR_W-1:0] seq_step(input logic [ADDR_W-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic sel_match(input logic [7:0] b, input logic [3:0] id, input logic [2:0] st);
    return b[7:1] == {id, st};
  endfunction

endpackage

// File: rtl/spike_filter.sv
module spike_filter #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(CYC + 1);

  logic s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      dout <= 1'b1;
      cnt  <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      if (s2 == dout) begin
        cnt <= '0;
      end else if (cnt == CW'(CYC - 1)) begin
        dout <= s2;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R12: the cleaned line only takes a value the synchroniser already held
  a_r12_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> (dout == $past(s2)))
    else $error("R12 filter output changed to a value not held by the input");

endmodule

// File: rtl/wr_timer.sv
module wr_timer #(
  parameter int CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= CW'(CYC);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/twi_eeprom.sv
module twi_eeprom
  import twi_eeprom_pkg::*;
#(
  parameter logic [3:0] DEV_ID     = 4'b1010,
  parameter int         SPIKE_CYC  = 4,
  parameter int         HOLD_CYC   = 6,
  parameter int         WR_CYC     = 500000,
  parameter int         PAGE_BYTES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_a,
  input  logic       wp_i,
  input  logic       lock_set_i,
  output logic       sda_oe,
  output logic       busy_o,
  output logic       lock_o
);
  localparam int PB    = $clog2(PAGE_BYTES);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HW    = $clog2(HOLD_CYC + 1);

  // ---- line cleaning and bus events
  logic [1:0] raw_w, flt_w;
  logic       scl_f, sda_f, scl_d, sda_d;
  assign raw_w = {sda_i, scl_i};

  for (genvar gi = 0; gi < 2; gi++) begin : g_flt
    spike_filter #(.CYC(SPIKE_CYC)) u_f (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_w[gi]),
      .dout (flt_w[gi])
    );
  end
  assign scl_f = flt_w[0];
  assign sda_f = flt_w[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  logic scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  assign start_ev = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_ev  = scl_f & scl_d & ~sda_d & sda_f;

  // ---- protocol state
  phase_e              st;
  logic [3:0]          bitn;
  logic                ackp, ack_drv, mack;
  logic [7:0]          rx, tx;
  logic [ADDR_W-1:0]   ptr;
  logic [7:0]          pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vmask;
  logic [7:0]          mem  [DEPTH];
  logic                lock_q = 1'b0;

  // ---- commit decision
  logic lock_now, blocked, commit_req, commit_ev, byte_done;
  assign lock_now   = lock_q | lock_set_i;
  assign blocked    = wp_i | (lock_now & ~ptr[ADDR_W-1]);
  assign commit_req = stop_ev & ~busy_o & (st == S_WDAT) & (|vmask);
  assign commit_ev  = commit_req & ~blocked;
  assign byte_done  = scl_fall & ~ackp & (bitn == 4'd8) & (st != S_IDLE);

  wr_timer #(.CYC(WR_CYC)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .start(commit_ev),
    .busy (busy_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      bitn    <= '0;
      ackp    <= 1'b0;
      ack_drv <= 1'b0;
      mack    <= 1'b1;
      rx      <= '0;
      tx      <= 8'hFF;
      ptr     <= '0;
      vmask   <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
    end else if (busy_o) begin
      st      <= S_IDLE;
      bitn    <= '0;
      ackp    <= 1'b0;
      ack_drv <= 1'b0;
    end else if (start_ev) begin
      st      <= S_SEL;
      bitn    <= '0;
      ackp    <= 1'b0;
      ack_drv <= 1'b0;
      vmask   <= '0;
    end else if (stop_ev) begin
      st      <= S_IDLE;
      bitn    <= '0;
      ackp    <= 1'b0;
      ack_drv <= 1'b0;
      vmask   <= '0;
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (!ackp) begin
          rx   <= {rx[6:0], sda_f};
          bitn <= bitn + 1'b1;
        end else begin
          mack <= sda_f;
        end
      end
      if (byte_done) begin
        ackp <= 1'b1;
        case (st)
          S_SEL: begin
            if (sel_match(rx, DEV_ID, strap_a)) begin
              ack_drv <= 1'b1;
              mack    <= 1'b0;
              st      <= rx[0] ? S_RDAT : S_WADR;
            end else begin
              ack_drv <= 1'b0;
              st      <= S_IDLE;
            end
          end
          S_WADR: begin
            ptr     <= rx;
            ack_drv <= 1'b1;
            st      <= S_WDAT;
          end
          S_WDAT: begin
            pbuf[ptr[PB-1:0]]  <= rx;
            vmask[ptr[PB-1:0]] <= 1'b1;
            ptr                <= page_step(ptr, PB);
            ack_drv            <= 1'b1;
          end
          default: ack_drv <= 1'b0;
        endcase
      end else if (scl_fall && ackp) begin
        ackp    <= 1'b0;
        bitn    <= '0;
        ack_drv <= 1'b0;
        if (st == S_RDAT) begin
          if (!mack) begin
            tx  <= mem[ptr];
            ptr <= seq_step(ptr);
          end else begin
            st  <= S_IDLE;
          end
        end
      end else if (scl_fall && st == S_RDAT) begin
        tx <= {tx[6:0], 1'b1};
      end
    end
  end

  // ---- array and one-time lock
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit_ev) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (vmask[i]) mem[{ptr[ADDR_W-1:PB], PB'(i)}] <= pbuf[i];
    end
  end

  always_ff @(posedge clk) begin
    if (lock_set_i) lock_q <= 1'b1;
  end
  assign lock_o = lock_q;

  // ---- SDA drive with hold after SCL falls
  logic          sda_want;
  logic [HW-1:0] hcnt;
  assign sda_want = (ackp & ack_drv) | ((st == S_RDAT) & ~ackp & ~tx[7]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt   <= '0;
      sda_oe <= 1'b0;
    end else begin
      if (scl_fall)                     hcnt <= '0;
      else if (hcnt != HW'(HOLD_CYC))   hcnt <= hcnt + 1'b1;
      if (!scl_f && !scl_fall && hcnt == HW'(HOLD_CYC)) sda_oe <= sda_want;
    end
  end

  // ---- assertions
  a_r7_commit_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |=> busy_o)
    else $error("R7 commit without busy window");

  a_r8_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_oe)
    else $error("R8 SDA driven while busy");

  a_r10_wp_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && wp_i && !busy_o) |=> !busy_o)
    else $error("R10 busy window started under write protect");

  a_r11_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |=> lock_o)
    else $error("R11 lock cleared");

  a_r13_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_f)
    else $error("R13 SDA drive changed while SCL high");

  a_r2_reject_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st == S_SEL && !sel_match(rx, DEV_ID, strap_a)) |=> !ack_drv)
    else $error("R2 acknowledge on foreign select");

endmodule

// File: tb/sim_twi_eeprom.sv
module sim_twi_eeprom;
  localparam int CLK_NS = 10;
  localparam int Q      = 20;
  localparam int WR     = 1500;
  localparam int HOLD   = 6;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] SELW  = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] SELR  = {4'b1010, STRAP, 1'b1};
  localparam logic [7:0] SELX  = {4'b1010, 3'b100, 1'b0};

  logic clk = 0;
  logic rst_n = 0;
  logic m_scl = 1, m_sda = 1;
  logic wp = 0, lock = 0;
  logic sda_oe, busy_o, lock_o;
  wire  sda_bus = m_sda & ~sda_oe;

  always #(CLK_NS/2) clk = ~clk;

  twi_eeprom #(.SPIKE_CYC(4), .HOLD_CYC(HOLD), .WR_CYC(WR)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .strap_a(STRAP),
    .wp_i(wp), .lock_set_i(lock), .sda_oe(sda_oe), .busy_o(busy_o), .lock_o(lock_o));

  int nchk = 0, nerr = 0;
  int busy_len = 0;
  bit lockd = 0;
  logic [7:0] model [256];
  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];
  string      tag_q [$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) if (busy_o) busy_len++;

  // R13 monitor on the raw bus
  int sc_cnt = 0, viol = 0, toggles = 0;
  logic prev_scl = 1, prev_oe = 0;
  always @(negedge clk) begin
    if (prev_scl && !m_scl) sc_cnt = 0; else sc_cnt++;
    if (rst_n && sda_oe !== prev_oe) begin
      toggles++;
      if (m_scl || sc_cnt < HOLD) viol++;
    end
    prev_scl = m_scl;
    prev_oe  = sda_oe;
  end

  // scoreboard monitor
  initial begin
    forever begin
      logic [7:0] g, e;
      string t;
      wait (got_q.size() != 0);
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(g == e, t, g, e);
    end
  end

  task automatic start_c();
    m_sda = 1; tick(Q);
    m_scl = 1; tick(Q);
    m_sda = 0; tick(Q);
    m_scl = 0; tick(Q);
  endtask

  task automatic stop_c();
    m_sda = 0; tick(Q);
    m_scl = 1; tick(Q);
    m_sda = 1; tick(2*Q);
  endtask

  task automatic bitx(input bit b, output bit s, input bit gl);
    m_sda = b; tick(Q);
    if (gl) begin m_scl = 1; tick(2); m_scl = 0; tick(Q); end
    m_scl = 1; tick(Q);
    if (gl) begin m_sda = ~b; tick(2); m_sda = b; tick(2); end
    s = sda_bus; tick(Q);
    m_scl = 0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack, input bit gl);
    bit s;
    for (int i = 7; i >= 0; i--) bitx(b[i], s, gl);
    bitx(1'b1, s, 1'b0);
    ack = !s;
  endtask

  task automatic rbyte(input bit ackit, output logic [7:0] v);
    bit s;
    for (int i = 0; i < 8; i++) begin bitx(1'b1, s, 1'b0); v = {v[6:0], s}; end
    bitx(!ackit, s, 1'b0);
  endtask

  task automatic wait_idle(input string tg);
    while (busy_o) tick(1);
    chk(busy_len == WR, {tg, " R7 busy length"}, busy_len, WR);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d[$], input string tg,
                    input bit gl, input bit lk, input bit waitb);
    bit ok, blk;
    logic [7:0] p;
    start_c();
    wbyte(SELW, ok, 1'b0); chk(ok, {tg, " R3 select ack"}, ok, 1);
    wbyte(a, ok, 1'b0);    chk(ok, {tg, " R3 address ack"}, ok, 1);
    foreach (d[k]) begin
      wbyte(d[k], ok, gl && k == 0);
      chk(ok, {tg, " R4 data ack"}, ok, 1);
    end
    blk = wp || ((lockd || lk) && !a[7]);
    if (!blk) begin
      p = a;
      foreach (d[k]) begin model[p] = d[k]; p = {p[7:4], p[3:0] + 4'd1}; end
    end
    if (lk) lock = 1;
    busy_len = 0;
    stop_c();
    if (lk) begin lock = 0; lockd = 1; end
    chk(busy_o == !blk, {tg, " busy after Stop"}, busy_o, !blk);
    if (waitb && busy_o) wait_idle(tg);
  endtask

  task automatic rd_at(input logic [7:0] a, input int n, input string tg, input bit useaddr);
    bit ok;
    logic [7:0] v;
    start_c();
    if (useaddr) begin
      wbyte(SELW, ok, 1'b0); chk(ok, {tg, " R3 select ack"}, ok, 1);
      wbyte(a, ok, 1'b0);    chk(ok, {tg, " R3 address ack"}, ok, 1);
      start_c();
    end
    wbyte(SELR, ok, 1'b0); chk(ok, {tg, " R9 read select ack"}, ok, 1);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(model[8'(a + 8'(k))]);
      tag_q.push_back(tg);
      rbyte(k != n - 1, v);
      got_q.push_back(v);
    end
    stop_c();
  endtask

  task automatic finish_run();
    wait (got_q.size() == 0);
    tick(2);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    bit ok;
    logic [7:0] d [$];
    logic [7:0] v;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    tick(5);
    chk(sda_oe == 0 && busy_o == 0, "R1 reset outputs", {sda_oe, busy_o}, 0);
    rst_n = 1; tick(10);
    chk(sda_oe == 0 && busy_o == 0, "R1 after reset", {sda_oe, busy_o}, 0);
    chk(lock_o == 0, "R11 lock clear at power-up", lock_o, 0);

    rd_at(8'h10, 2, "R1 array zero", 1'b1);

    // R2: foreign select, then nothing acknowledged until the next Start
    start_c();
    wbyte(SELX, ok, 1'b0); chk(!ok, "R2 foreign select nack", ok, 0);
    wbyte(8'h00, ok, 1'b0); chk(!ok, "R2 ignored until Start", ok, 0);
    stop_c();
    chk(busy_o == 0, "R2 no commit", busy_o, 0);

    // R3 R4 R7 plain page write, then read back
    d = '{8'h11, 8'h22, 8'h33};
    wr(8'h10, d, "R4 write", 1'b0, 1'b0, 1'b1);
    rd_at(8'h10, 3, "R9 sequential read", 1'b1);
    rd_at(8'h13, 1, "R9 current pointer", 1'b0);

    // R8: select during the busy window
    d = '{8'h44};
    wr(8'h40, d, "R8 setup", 1'b0, 1'b0, 1'b0);
    start_c();
    wbyte(SELW, ok, 1'b0); chk(!ok, "R8 no ack while busy", ok, 0);
    stop_c();
    chk(busy_o == 1, "R8 still busy", busy_o, 1);
    while (busy_o) tick(1);
    rd_at(8'h40, 1, "R8 data written", 1'b1);

    // R6: repeated Start before Stop discards the data
    start_c();
    wbyte(SELW, ok, 1'b0); chk(ok, "R6 select ack", ok, 1);
    wbyte(8'h60, ok, 1'b0); chk(ok, "R6 address ack", ok, 1);
    wbyte(8'h77, ok, 1'b0); chk(ok, "R6 data ack", ok, 1);
    start_c();
    wbyte(SELR, ok, 1'b0); chk(ok, "R6 read select ack", ok, 1);
    rbyte(1'b0, v); chk(v == 8'h00, "R6 pointer moved, no commit", v, 0);
    stop_c();
    chk(busy_o == 0, "R6 no busy window", busy_o, 0);
    rd_at(8'h60, 1, "R6 nothing committed", 1'b1);

    // R5: 18 bytes into page 0x20
    d = {};
    for (int k = 0; k < 18; k++) d.push_back(8'(8'h80 + k));
    wr(8'h20, d, "R5 page wrap", 1'b0, 1'b0, 1'b1);
    rd_at(8'h20, 3, "R5 overwrite and wrap", 1'b1);
    rd_at(8'h2F, 2, "R9 read crosses page", 1'b1);

    // R9: read wraps 255 -> 0
    d = '{8'hC3};
    wr(8'h00, d, "R9 setup low", 1'b0, 1'b0, 1'b1);
    d = '{8'h5A};
    wr(8'hFF, d, "R9 setup high", 1'b0, 1'b0, 1'b1);
    rd_at(8'hFF, 2, "R9 wrap at 255", 1'b1);

    // R10: write protect pin
    wp = 1;
    d = '{8'hEE};
    wr(8'h80, d, "R10 wp", 1'b0, 1'b0, 1'b1);
    wp = 0;
    rd_at(8'h80, 1, "R10 unchanged", 1'b1);

    // R11: lock pulse overlapping the commit, then upper half still writable
    d = '{8'h99};
    wr(8'h05, d, "R11 lock at commit", 1'b0, 1'b1, 1'b1);
    chk(lock_o == 1, "R11 lock set", lock_o, 1);
    rd_at(8'h05, 1, "R11 lower unchanged", 1'b1);
    d = '{8'hDD};
    wr(8'h90, d, "R11 upper allowed", 1'b0, 1'b0, 1'b1);
    rd_at(8'h90, 1, "R11 upper written", 1'b1);
    rst_n = 0; tick(4); rst_n = 1; tick(10);
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    chk(lock_o == 1, "R11 lock survives reset", lock_o, 1);
    d = '{8'h12};
    wr(8'h06, d, "R11 lower blocked after reset", 1'b0, 1'b0, 1'b1);
    rd_at(8'h06, 1, "R11 lower still zero", 1'b1);

    // R12: spikes on both lines during every bit of the data byte
    d = '{8'h5B};
    wr(8'hA0, d, "R12 spikes", 1'b1, 1'b0, 1'b1);
    rd_at(8'hA0, 1, "R12 data intact", 1'b1);

    chk(viol == 0, "R13 hold after SCL fall", viol, 0);
    chk(toggles > 0, "R13 SDA was driven", toggles, 1);

    finish_run();
  end

endmodule